// File: doc/BRIEF.md
# Accumulated-Count Display Timing Generator

This block drives the control side of a parallel RGB panel. It produces horizontal sync, vertical sync and a data-enable strobe, and gives the panel a pixel colour for every active position. Each axis is set up with four cumulative boundary values rather than with separate widths. Each value is one less than a running sum: the end of sync, the end of the back porch, the end of the active region, and the last count of the line or frame. Zero-width porches are therefore allowed, and every boundary is a plain compare against the counter.

The live horizontal and vertical counts are driven out on the position ports. A downstream layer stage can decide combinationally whether a position falls inside its window and return a pixel with a valid flag in the same cycle. The block registers that pixel together with the sync and data-enable state for the same position. Inside the active area, a position with no valid layer pixel shows a stored background colour; outside it the colour bus is zero.

Each control output has its own polarity select. A separate output tells the panel-clock logic on which edge to launch data. A global enable starts the timing; while it is low the counters sit at zero and every control output rests at its inactive level.

Top module: `disp_timing_gen`

## Requirements
- R1: While `enable` is high, `h_pos` counts up by one each cycle from 0, and returns to 0 on the cycle after it reaches (or exceeds) `h_total`.
- R2: `v_pos` changes only on the cycle after `h_pos` wraps. At that point it goes up by one, or returns to 0 if it had reached `v_total`.
- R3: The sync state shown one cycle after a position P is asserted on each axis exactly when that axis' count in P is at or below its `*_sync_end` value.
- R4: The data-enable shown one cycle after position P is asserted exactly when the horizontal count of P is above `h_bp_end` and at or below `h_act_end`, and the vertical count of P meets the same test against `v_bp_end` and `v_act_end`.
- R5: Each of `hsync`, `vsync` and `de` follows its own select: when the select is 1 the asserted level is 1, and when it is 0 the asserted level is 0. The inactive level is always the inverse. A change of select applies in the same cycle.
- R6: `launch_fall` is 1 one cycle after an edge at which `enable` is high and `pclk_rise` is 0. Otherwise it is 0.
- R7: One cycle after position P, `rgb_out` carries `layer_rgb` when data-enable is asserted for P and `layer_valid` was high. It carries the background colour when data-enable is asserted and `layer_valid` was low. It is 0 whenever data-enable is not asserted. The colour is packed red[23:16], green[15:8], blue[7:0].
- R8: The background colour is black (0) after reset. It takes `bg_data` at an edge where `bg_wr` is high, and that new value is first used for the position that follows that edge.
- R9: At an edge with `enable` low, both counters go to 0, and the sync, data-enable, `launch_fall` and colour outputs go to their inactive values.
- R10: During and right after reset, the positions and colour are 0, `launch_fall` is 0, and every control output sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global timing enable |
| h_sync_end | input | 12 | Horizontal sync width minus 1 |
| h_bp_end | input | 12 | Horizontal sync plus back porch minus 1 |
| h_act_end | input | 12 | Horizontal sync plus back porch plus active width minus 1 |
| h_total | input | 12 | Whole line length minus 1 |
| v_sync_end | input | 12 | Vertical sync height minus 1 (lines) |
| v_bp_end | input | 12 | Vertical sync plus back porch minus 1 |
| v_act_end | input | 12 | Vertical sync plus back porch plus active height minus 1 |
| v_total | input | 12 | Whole frame height minus 1 |
| hs_active_high | input | 1 | 1: hsync asserted high |
| vs_active_high | input | 1 | 1: vsync asserted high |
| de_active_high | input | 1 | 1: data-enable asserted high |
| pclk_rise | input | 1 | 1: data launched for the rising panel clock edge |
| bg_wr | input | 1 | Load strobe for the background colour |
| bg_data | input | 24 | New background colour (R, G, B bytes) |
| layer_valid | input | 1 | A layer pixel is present for the current position |
| layer_rgb | input | 24 | Layer pixel for the current position |
| h_pos | output | 12 | Live horizontal count |
| v_pos | output | 12 | Live vertical count |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| launch_fall | output | 1 | 1: launch data for the falling panel clock edge |
| rgb_out | output | 24 | Pixel colour to the panel |

## Verification
Some boundary layouts are hard to reach from the ports: a sync of one count, zero-length back or front porches where one region ends exactly where the next begins, and a drop of `enable` part way through a line. Each of these changes which compare is true at the wrap points. The bench steps through directed layouts with one-count regions and a zero-width porch, then draws fresh accumulated layouts and polarities from a seeded generator. It also pulls `enable` low at random cycles. It models the counters and the one-cycle output register on its own and compares every output on every cycle.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
  } dtg_rgb_t;

  localparam int unsigned RGB_W = $bits(dtg_rgb_t);

  // Inclusive upper bound: a count is inside sync while at or below its end value.
  function automatic logic dtg_in_sync(input logic [15:0] cnt, input logic [15:0] sync_end);
    return cnt <= sync_end;
  endfunction

  // Active region is the half-open span (bp_end, act_end].
  function automatic logic dtg_in_active(input logic [15:0] cnt,
                                         input logic [15:0] bp_end,
                                         input logic [15:0] act_end);
    return (cnt > bp_end) && (cnt <= act_end);
  endfunction

  // Drive a raw assertion flag at the selected level.
  function automatic logic dtg_level(input logic asserted, input logic active_high);
    return active_high ? asserted : ~asserted;
  endfunction

endpackage

// File: rtl/dtg_axis_counter.sv
module dtg_axis_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  assign wrap = step && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enable) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dtg_axis_window.sv
module dtg_axis_window
  import dtg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] sync_end,
  input  logic [W-1:0] bp_end,
  input  logic [W-1:0] act_end,
  output logic         in_sync,
  output logic         in_active
);

  localparam int unsigned PADW = 16 - W;

  logic [15:0] cnt_x, sync_x, bp_x, act_x;

  generate
    if (PADW == 0) begin : g_nopad
      assign cnt_x  = cnt;
      assign sync_x = sync_end;
      assign bp_x   = bp_end;
      assign act_x  = act_end;
    end else begin : g_pad
      assign cnt_x  = {{PADW{1'b0}}, cnt};
      assign sync_x = {{PADW{1'b0}}, sync_end};
      assign bp_x   = {{PADW{1'b0}}, bp_end};
      assign act_x  = {{PADW{1'b0}}, act_end};
    end
  endgenerate

  assign in_sync   = dtg_in_sync(cnt_x, sync_x);
  assign in_active = dtg_in_active(cnt_x, bp_x, act_x);

endmodule

// File: rtl/dtg_pixel_stage.sv
module dtg_pixel_stage
  import dtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 h_in_sync,
  input  logic                 v_in_sync,
  input  logic                 h_in_active,
  input  logic                 v_in_active,
  input  logic                 pclk_rise,
  input  logic                 bg_wr,
  input  logic [RGB_W-1:0]     bg_data,
  input  logic                 layer_valid,
  input  logic [RGB_W-1:0]     layer_rgb,
  output logic                 hs_flag,
  output logic                 vs_flag,
  output logic                 de_flag,
  output logic                 fall_flag,
  output logic [RGB_W-1:0]     rgb_q
);

  dtg_rgb_t bg_q;
  dtg_rgb_t pix_d;
  logic     de_d;

  assign de_d  = h_in_active && v_in_active;
  assign pix_d = !de_d        ? dtg_rgb_t'('0) :
                 layer_valid  ? dtg_rgb_t'(layer_rgb) : bg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bg_q <= '0;
    end else if (bg_wr) begin
      bg_q <= dtg_rgb_t'(bg_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_flag   <= 1'b0;
      vs_flag   <= 1'b0;
      de_flag   <= 1'b0;
      fall_flag <= 1'b0;
      rgb_q     <= '0;
    end else if (!enable) begin
      hs_flag   <= 1'b0;
      vs_flag   <= 1'b0;
      de_flag   <= 1'b0;
      fall_flag <= 1'b0;
      rgb_q     <= '0;
    end else begin
      hs_flag   <= h_in_sync;
      vs_flag   <= v_in_sync;
      de_flag   <= de_d;
      fall_flag <= ~pclk_rise;
      rgb_q     <= pix_d;
    end
  end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [W-1:0]     h_sync_end,
  input  logic [W-1:0]     h_bp_end,
  input  logic [W-1:0]     h_act_end,
  input  logic [W-1:0]     h_total,
  input  logic [W-1:0]     v_sync_end,
  input  logic [W-1:0]     v_bp_end,
  input  logic [W-1:0]     v_act_end,
  input  logic [W-1:0]     v_total,
  input  logic             hs_active_high,
  input  logic             vs_active_high,
  input  logic             de_active_high,
  input  logic             pclk_rise,
  input  logic             bg_wr,
  input  logic [23:0]      bg_data,
  input  logic             layer_valid,
  input  logic [23:0]      layer_rgb,
  output logic [W-1:0]     h_pos,
  output logic [W-1:0]     v_pos,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             launch_fall,
  output logic [23:0]      rgb_out
);

  logic h_wrap, v_wrap;
  logic h_in_sync, h_in_active, v_in_sync, v_in_active;
  logic hs_flag, vs_flag, de_flag;

  dtg_axis_counter #(.W(W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step(1'b1),
    .limit(h_total), .cnt(h_pos), .wrap(h_wrap)
  );

  dtg_axis_counter #(.W(W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step(h_wrap),
    .limit(v_total), .cnt(v_pos), .wrap(v_wrap)
  );

  dtg_axis_window #(.W(W)) u_hwin (
    .cnt(h_pos), .sync_end(h_sync_end), .bp_end(h_bp_end), .act_end(h_act_end),
    .in_sync(h_in_sync), .in_active(h_in_active)
  );

  dtg_axis_window #(.W(W)) u_vwin (
    .cnt(v_pos), .sync_end(v_sync_end), .bp_end(v_bp_end), .act_end(v_act_end),
    .in_sync(v_in_sync), .in_active(v_in_active)
  );

  dtg_pixel_stage u_pix (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .h_in_sync(h_in_sync), .v_in_sync(v_in_sync),
    .h_in_active(h_in_active), .v_in_active(v_in_active),
    .pclk_rise(pclk_rise), .bg_wr(bg_wr), .bg_data(bg_data),
    .layer_valid(layer_valid), .layer_rgb(layer_rgb),
    .hs_flag(hs_flag), .vs_flag(vs_flag), .de_flag(de_flag),
    .fall_flag(launch_fall), .rgb_q(rgb_out)
  );

  assign hsync = dtg_level(hs_flag, hs_active_high);
  assign vsync = dtg_level(vs_flag, vs_active_high);
  assign de    = dtg_level(de_flag, de_active_high);

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic [W-1:0] h_total,
  input logic [W-1:0] v_total,
  input logic [W-1:0] h_pos,
  input logic [W-1:0] v_pos,
  input logic         h_wrap,
  input logic         hsync,
  input logic         vsync,
  input logic         de,
  input logic         hs_active_high,
  input logic         vs_active_high,
  input logic         de_active_high,
  input logic         launch_fall,
  input logic [23:0]  rgb_out
);

  assert_h_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (h_pos < h_total)) |=> (!$past(enable) || (h_pos == W'($past(h_pos) + 1'b1))));

  assert_h_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (h_pos >= h_total)) |=> (h_pos == '0));

  assert_v_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !h_wrap) |=> $stable(v_pos));

  assert_v_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && h_wrap && (v_pos >= v_total)) |=> (v_pos == '0));

  assert_black_outside_de_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (de != de_active_high) |-> (rgb_out == '0));

  assert_idle_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((h_pos == '0) && (v_pos == '0) && (hsync != hs_active_high) &&
                 (vsync != vs_active_high) && (de != de_active_high) && !launch_fall));

endmodule

bind disp_timing_gen dtg_checker #(.W(W)) u_dtg_checker (
  .clk(clk), .rst_n(rst_n), .enable(enable), .h_total(h_total), .v_total(v_total),
  .h_pos(h_pos), .v_pos(v_pos), .h_wrap(h_wrap), .hsync(hsync), .vsync(vsync), .de(de),
  .hs_active_high(hs_active_high), .vs_active_high(vs_active_high),
  .de_active_high(de_active_high), .launch_fall(launch_fall), .rgb_out(rgb_out)
);

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [11:0] h_sync_end = '0, h_bp_end = '0, h_act_end = '0, h_total = '0;
  logic [11:0] v_sync_end = '0, v_bp_end = '0, v_act_end = '0, v_total = '0;
  logic hs_active_high = 1'b0, vs_active_high = 1'b0, de_active_high = 1'b1;
  logic pclk_rise = 1'b1;
  logic bg_wr = 1'b0;
  logic [23:0] bg_data = '0;
  logic layer_valid = 1'b0;
  logic [23:0] layer_rgb = '0;
  logic [11:0] h_pos, v_pos;
  logic hsync, vsync, de, launch_fall;
  logic [23:0] rgb_out;

  int checks = 0;
  int fails = 0;
  logic [11:0] mh = '0, mv = '0;
  logic [23:0] bgm = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_timing_gen i_disp_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .h_sync_end(h_sync_end), .h_bp_end(h_bp_end), .h_act_end(h_act_end), .h_total(h_total),
    .v_sync_end(v_sync_end), .v_bp_end(v_bp_end), .v_act_end(v_act_end), .v_total(v_total),
    .hs_active_high(hs_active_high), .vs_active_high(vs_active_high),
    .de_active_high(de_active_high), .pclk_rise(pclk_rise),
    .bg_wr(bg_wr), .bg_data(bg_data), .layer_valid(layer_valid), .layer_rgb(layer_rgb),
    .h_pos(h_pos), .v_pos(v_pos), .hsync(hsync), .vsync(vsync), .de(de),
    .launch_fall(launch_fall), .rgb_out(rgb_out)
  );

  function automatic bit exp_level(input bit on, input bit hi);
    return hi ? on : !on;
  endfunction

  function automatic bit exp_in_span(input logic [11:0] c, input logic [11:0] lo, input logic [11:0] hi);
    return (c > lo) && !(c > hi);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (h_pos=%0d v_pos=%0d)", req, act, exp, h_pos, v_pos);
    end
  endtask

  // Accumulated layout from widths; front porch may be zero.
  task automatic layout(input int hs, input int hb, input int ha, input int hf,
                        input int vs, input int vb, input int va, input int vf);
    h_sync_end = 12'(hs - 1);
    h_bp_end   = 12'(hs + hb - 1);
    h_act_end  = 12'(hs + hb + ha - 1);
    h_total    = 12'(hs + hb + ha + hf - 1);
    v_sync_end = 12'(vs - 1);
    v_bp_end   = 12'(vs + vb - 1);
    v_act_end  = 12'(vs + vb + va - 1);
    v_total    = 12'(vs + vb + va + vf - 1);
  endtask

  task automatic tick();
    logic [11:0] ph, pv;
    bit ehs, evs, ede, elf;
    logic [23:0] ergb;
    @(posedge clk);
    ph = mh; pv = mv;
    if (enable) begin
      ehs  = !(ph > h_sync_end);
      evs  = !(pv > v_sync_end);
      ede  = exp_in_span(ph, h_bp_end, h_act_end) && exp_in_span(pv, v_bp_end, v_act_end);
      elf  = !pclk_rise;
      ergb = !ede ? 24'h0 : (layer_valid ? layer_rgb : bgm);
      if (mh >= h_total) begin
        mh = '0;
        mv = (mv >= v_total) ? 12'h0 : mv + 12'h1;
      end else begin
        mh = mh + 12'h1;
      end
    end else begin
      ehs = 0; evs = 0; ede = 0; elf = 0; ergb = '0;
      mh = '0; mv = '0;
    end
    if (bg_wr) bgm = bg_data;
    @(negedge clk);
    chk("R1 h_pos", 32'(h_pos), 32'(mh));
    chk("R2 v_pos", 32'(v_pos), 32'(mv));
    chk(enable ? "R3/R5 hsync" : "R9 hsync", 32'(hsync), 32'(exp_level(ehs, hs_active_high)));
    chk(enable ? "R3/R5 vsync" : "R9 vsync", 32'(vsync), 32'(exp_level(evs, vs_active_high)));
    chk(enable ? "R4/R5 de" : "R9 de", 32'(de), 32'(exp_level(ede, de_active_high)));
    chk("R6 launch_fall", 32'(launch_fall), 32'(elf));
    chk(bg_wr ? "R8 rgb_out" : "R7 rgb_out", 32'(rgb_out), 32'(ergb));
  endtask

  task automatic run(input int n, input int drop_pct);
    for (int i = 0; i < n; i++) begin
      layer_valid = ($urandom % 2) == 1;
      layer_rgb   = 24'($urandom);
      bg_wr       = ($urandom % 50) == 0;
      bg_data     = 24'($urandom);
      enable      = !(($urandom % 100) < drop_pct);
      tick();
    end
    bg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h0d15_7a11));
    layout(2, 2, 6, 2, 1, 1, 3, 1);
    repeat (3) @(negedge clk);
    // R10: state held in reset
    chk("R10 h_pos", 32'(h_pos), 0);
    chk("R10 v_pos", 32'(v_pos), 0);
    chk("R10 hsync", 32'(hsync), 32'(!hs_active_high));
    chk("R10 de", 32'(de), 32'(!de_active_high));
    chk("R10 rgb_out", 32'(rgb_out), 0);
    chk("R10 launch_fall", 32'(launch_fall), 0);
    rst_n = 1'b1;
    tick();
    // R8: background is black before any write (layer absent)
    enable = 1'b1; layer_valid = 1'b0;
    for (int i = 0; i < 80; i++) tick();
    // R8: write a background, then a frame with no layer
    bg_wr = 1'b1; bg_data = 24'hA5_3C_7E; tick(); bg_wr = 1'b0;
    for (int i = 0; i < 80; i++) tick();
    // Directed: one-count regions everywhere, zero front porch
    enable = 1'b0; tick();
    layout(1, 1, 1, 0, 1, 1, 1, 0);
    hs_active_high = 1; vs_active_high = 1; de_active_high = 0; pclk_rise = 0;
    enable = 1'b1;
    run(60, 0);
    // Directed: zero back porch, mid-line enable drops
    enable = 1'b0; tick();
    layout(1, 0, 4, 3, 2, 0, 2, 1);
    hs_active_high = 0; de_active_high = 1; pclk_rise = 1;
    run(200, 5);
    // R5: polarity change while idle takes effect at once
    enable = 1'b0; tick();
    hs_active_high = 1; vs_active_high = 0; de_active_high = 0; #1;
    chk("R5 hsync idle", 32'(hsync), 0);
    chk("R5 vsync idle", 32'(vsync), 1);
    chk("R5 de idle", 32'(de), 1);
    // Random layouts and polarities
    for (int c = 0; c < 10; c++) begin
      enable = 1'b0; tick();
      layout(1 + $urandom % 4, $urandom % 4, 1 + $urandom % 10, $urandom % 4,
             1 + $urandom % 3, $urandom % 3, 1 + $urandom % 6, $urandom % 3);
      hs_active_high = 1'($urandom); vs_active_high = 1'($urandom);
      de_active_high = 1'($urandom); pclk_rise = 1'($urandom);
      run(700, (c % 3 == 0) ? 2 : 0);
    end
    summary();
    $finish;
  end

endmodule